// File: doc/BRIEF.md
# Serial Multichannel DAC Writer

This block feeds a serial digital-to-analog converter from a packet of channel updates. A host first loads the packet into a small byte buffer through a write port. Byte 0 holds the number of records. The records follow from address 1, three bytes each: the low byte of the value, then its high byte, then the channel byte. The host then pulses `start`.

The block walks the records in order. For each record it builds a 16-bit frame and shifts it out on a chip-select, serial-clock and data line. It then moves to the next record until the count is used up. The first frame byte carries the two channel bits, two fixed mode bits (internal clock, bipolar range) and the high nibble of the value. The second frame byte is the low byte of the value.

While a packet is in progress, `busy` is high. New starts and buffer writes are refused until the last frame has finished.

Top module: `dacw_top`

## Requirements
- R1: After reset, `dac_cs_n` is 1, `dac_sclk` is 0, `dac_sdo` is 0 and `busy` is 0.
- R2: Bits 15:8 of each frame are built as follows. Bits 15:14 are bits 7:6 of the channel byte. Bits 13:12 are both 1. Bits 11:8 are bits 3:0 of the high byte. Bits 7:4 of the high byte and bits 5:0 of the channel byte are discarded.
- R3: Bits 7:0 of each frame equal the record's low byte.
- R4: Each frame has exactly 16 serial clock pulses and is sent most significant bit first. Each pulse is high for HALF clock cycles. `dac_sdo` is set before the rising edge and does not change while `dac_sclk` is high.
- R5: `dac_cs_n` is low for the whole frame. `dac_sclk` is only high while `dac_cs_n` is low. `dac_cs_n` rises on the same clock edge as the last falling edge of `dac_sclk`.
- R6: The buffer layout is: count at address 0, then records of three bytes (low, high, channel) from address 1. Exactly `count` frames are sent, in record order.
- R7: A packet with count 0 sends no frame, and `busy` returns low.
- R8: Between two frames of one packet, `dac_cs_n` stays high for at least 2*HALF clock cycles.
- R9: `busy` rises in the cycle after an accepted `start`. It falls exactly 2*HALF cycles after `dac_cs_n` rises at the end of the last frame. A `start` seen while `busy` is high is ignored.
- R10: Buffer writes attempted while `busy` is high are ignored. The stored packet is unchanged, which a later start with the same buffer shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | ADDR_W | Buffer write address |
| wr_data | input | 8 | Buffer write byte |
| start | input | 1 | Begin walking the buffered packet |
| busy | output | 1 | Packet in progress |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_sclk | output | 1 | Serial clock |
| dac_sdo | output | 1 | Serial data to the converter |

## Verification
`busy` is due one clock after `start`. After the last frame, `busy` is due to drop 2*HALF clocks after `dac_cs_n` rises. The bench checks both, counting falling-edge samples from each event.

Frame contents are not checked against a fixed cycle. A falling-edge monitor detects each rising serial-clock edge, shifts in `dac_sdo` at that point, and measures the high width and the chip-select gaps. The bench therefore checks content and pulse shape wherever the walker's fetch latency places a frame. Each collected frame is then compared with the value the bench computes arithmetically from the record.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] CH_KEEP   = 8'hC0;
  localparam logic [BYTE_W-1:0] MODE_FIX  = 8'h30;

  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} shift_st_t;

  typedef enum logic [3:0] {
    W_IDLE, W_CNT_REQ, W_CNT_TAKE, W_LO_REQ, W_LO_TAKE,
    W_HI_REQ, W_HI_TAKE, W_CH_REQ, W_CH_TAKE, W_WAIT
  } walk_st_t;

  // channel bits, fixed mode bits, high nibble of value; then low byte
  function automatic frame_t pack_frame(logic [BYTE_W-1:0] ch,
                                        logic [BYTE_W-1:0] hi,
                                        logic [BYTE_W-1:0] lo);
    logic [BYTE_W-1:0] top;
    top = (ch & CH_KEEP) | MODE_FIX | {4'h0, hi[3:0]};
    return {top, lo};
  endfunction
endpackage

// File: rtl/dacw_pktbuf.sv
module dacw_pktbuf #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter
  import dacw_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  frame_t frame,
  output logic   done,
  output logic   cs_n,
  output logic   sclk,
  output logic   sdo
);
  localparam int CW    = $clog2(2 * HALF) + 1;
  localparam int BITW  = $clog2(FRAME_W);
  localparam logic [CW-1:0]   HALF_END = CW'(HALF - 1);
  localparam logic [CW-1:0]   GAP_END  = CW'(2 * HALF - 1);
  localparam logic [BITW-1:0] LAST_BIT = BITW'(FRAME_W - 1);

  shift_st_t       st;
  logic [CW-1:0]   cnt;
  logic [BITW-1:0] bitn;
  frame_t          sreg;

  assign done = (st == S_GAP) && (cnt == GAP_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sreg <= '0;
      cs_n <= 1'b1;
      sclk <= 1'b0;
      sdo  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (load) begin
            sreg <= frame;
            sdo  <= frame[FRAME_W-1];
            cs_n <= 1'b0;
            cnt  <= '0;
            bitn <= '0;
            st   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitn == LAST_BIT) begin
                cs_n <= 1'b1;
                st   <= S_GAP;
              end else begin
                bitn <= bitn + 1'b1;
                sreg <= {sreg[FRAME_W-2:0], 1'b0};
                sdo  <= sreg[FRAME_W-2];
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == GAP_END) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dacw_walker.sv
module dacw_walker
  import dacw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] rd_q,
  input  logic              frame_done,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              load,
  output frame_t            frame,
  output logic              busy
);
  walk_st_t          st;
  logic [BYTE_W-1:0] left;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;

  assign busy = (st != W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= W_IDLE;
      rd_addr <= '0;
      left    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      frame   <= '0;
      load    <= 1'b0;
    end else begin
      load <= 1'b0;
      case (st)
        W_IDLE: if (start) begin
          rd_addr <= '0;
          st      <= W_CNT_REQ;
        end
        W_CNT_REQ: st <= W_CNT_TAKE;
        W_CNT_TAKE: begin
          left    <= rd_q;
          rd_addr <= rd_addr + 1'b1;
          st      <= (rd_q == '0) ? W_IDLE : W_LO_REQ;
        end
        W_LO_REQ: st <= W_LO_TAKE;
        W_LO_TAKE: begin
          lo_q    <= rd_q;
          rd_addr <= rd_addr + 1'b1;
          st      <= W_HI_REQ;
        end
        W_HI_REQ: st <= W_HI_TAKE;
        W_HI_TAKE: begin
          hi_q    <= rd_q;
          rd_addr <= rd_addr + 1'b1;
          st      <= W_CH_REQ;
        end
        W_CH_REQ: st <= W_CH_TAKE;
        W_CH_TAKE: begin
          frame   <= pack_frame(rd_q, hi_q, lo_q);
          rd_addr <= rd_addr + 1'b1;
          load    <= 1'b1;
          st      <= W_WAIT;
        end
        W_WAIT: if (frame_done) begin
          if (left == 8'd1) begin
            st <= W_IDLE;
          end else begin
            left <= left - 1'b1;
            st   <= W_LO_REQ;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dacw_top.sv
module dacw_top
  import dacw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int HALF   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              start,
  output logic              busy,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdo
);
  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_q;
  logic              load;
  logic              frame_done;
  frame_t            frame;
  logic              wr_ok;

  assign wr_ok = wr_en & ~busy;

  dacw_pktbuf #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) buf_i (
    .clk(clk), .we(wr_ok), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_q)
  );

  dacw_walker #(.ADDR_W(ADDR_W)) walk_i (
    .clk(clk), .rst(rst), .start(start), .rd_q(rd_q),
    .frame_done(frame_done), .rd_addr(rd_addr), .load(load),
    .frame(frame), .busy(busy)
  );

  dacw_shifter #(.HALF(HALF)) shift_i (
    .clk(clk), .rst(rst), .load(load), .frame(frame),
    .done(frame_done), .cs_n(dac_cs_n), .sclk(dac_sclk), .sdo(dac_sdo)
  );
endmodule

// File: rtl/dacw_chk.sv
module dacw_chk #(
  parameter int HALF = 2
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic cs_n,
  input logic sclk,
  input logic sdo
);
  logic [7:0] hi_run;
  logic       in_pkt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      in_pkt <= 1'b0;
    end else begin
      if (!cs_n)                hi_run <= '0;
      else if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
      in_pkt <= busy ? (in_pkt | ~cs_n) : 1'b0;
    end
  end

  // R4: data held while the serial clock is high
  a_r4_sdo_hold: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdo));

  // R5: serial clock only pulses inside a frame
  a_r5_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  // R5: select releases together with the final clock fall
  a_r5_cs_release: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $fell(sclk));

  // R8: minimum select-high gap between frames of one packet
  a_r8_gap: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && in_pkt) |-> (hi_run >= 8'(2 * HALF)));

  // R9: accepted start raises busy next cycle
  a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R9: no frame outside a packet
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sclk));
endmodule

bind dacw_top dacw_chk #(.HALF(HALF)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .cs_n(dac_cs_n), .sclk(dac_sclk), .sdo(dac_sdo)
);

// File: tb/dacw_top_tb_top.sv
module dacw_top_tb_top;
  localparam int ADDR_W = 6;
  localparam int HALF   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              start = 1'b0;
  logic              busy, dac_cs_n, dac_sclk, dac_sdo;

  always #2 clk = ~clk;

  dacw_top #(.ADDR_W(ADDR_W), .HALF(HALF)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .busy(busy),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
  );

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  int wd_fail = 0;

  logic [15:0] got [0:255];
  int          got_n = 0;
  logic [7:0]  e_lo [0:20];
  logic [7:0]  e_hi [0:20];
  logic [7:0]  e_ch [0:20];

  // ---------------- monitor ----------------
  logic        prev_cs, prev_sclk, prev_busy, hold_bit, frame_seen;
  logic [15:0] shreg;
  int          bitc, hi_len, post_cnt;

  always @(negedge clk) begin
    if (rst) begin
      prev_cs = 1'b1; prev_sclk = 1'b0; prev_busy = 1'b0;
      frame_seen = 1'b0; bitc = 0; hi_len = 0; post_cnt = 0;
      shreg = '0; hold_bit = 1'b0;
    end else begin
      if (prev_cs && !dac_cs_n) begin
        bitc = 0;
        if (frame_seen) begin
          mon_checks++;
          if (post_cnt < 2 * HALF) begin
            mon_errors++;
            $display("FAIL R8 gap actual %0d expected >= %0d", post_cnt, 2 * HALF);
          end
        end
      end
      if (!prev_sclk && dac_sclk) begin
        shreg = {shreg[14:0], dac_sdo};
        bitc++;
        hold_bit = dac_sdo;
        hi_len = 1;
        mon_checks++;
        if (dac_cs_n) begin
          mon_errors++;
          $display("FAIL R5 sclk rose with cs_n actual %0b expected 0", dac_cs_n);
        end
      end else if (dac_sclk) begin
        hi_len++;
        if (dac_sdo !== hold_bit) begin
          mon_errors++;
          $display("FAIL R4 sdo moved while sclk high actual %0b expected %0b",
                   dac_sdo, hold_bit);
        end
      end
      if (prev_sclk && !dac_sclk) begin
        mon_checks++;
        if (hi_len != HALF) begin
          mon_errors++;
          $display("FAIL R4 sclk high width actual %0d expected %0d", hi_len, HALF);
        end
      end
      if (!prev_cs && dac_cs_n) begin
        mon_checks++;
        if (bitc != 16) begin
          mon_errors++;
          $display("FAIL R4 pulses per frame actual %0d expected 16", bitc);
        end
        mon_checks++;
        if (prev_sclk !== 1'b1 || dac_sclk !== 1'b0) begin
          mon_errors++;
          $display("FAIL R5 cs_n rise not at last sclk fall actual %0b%0b expected 10",
                   prev_sclk, dac_sclk);
        end
        if (got_n < 256) got[got_n] = shreg;
        got_n++;
        post_cnt = 1;
        frame_seen = 1'b1;
      end else if (dac_cs_n && busy) begin
        post_cnt++;
      end
      if (prev_busy && !busy) begin
        if (frame_seen) begin
          mon_checks++;
          if (post_cnt != 2 * HALF) begin
            mon_errors++;
            $display("FAIL R9 busy fall after last frame actual %0d expected %0d",
                     post_cnt, 2 * HALF);
          end
        end
        frame_seen = 1'b0;
      end
      prev_cs = dac_cs_n; prev_sclk = dac_sclk; prev_busy = busy;
    end
  end

  // ---------------- helpers ----------------
  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks + mon_checks,
             errors + mon_errors + wd_fail);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input int addr, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_pkt(input int n);
    put(0, 8'(n));
    for (int i = 0; i < n; i++) begin
      put(1 + 3 * i, e_lo[i]);
      put(2 + 3 * i, e_hi[i]);
      put(3 + 3 * i, e_ch[i]);
    end
  endtask

  task automatic go_wait(output int base);
    base = got_n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input int base, input int n);
    logic [7:0] eb1;
    chk(got_n - base == n, "R6 frame count", got_n - base, n);
    for (int i = 0; i < n; i++) begin
      eb1 = (e_ch[i] & 8'hC0) | 8'h30 | (e_hi[i] & 8'h0F);
      chk(got[base + i][15:8] == eb1, "R2 first byte", got[base + i][15:8], eb1);
      chk(got[base + i][7:0] == e_lo[i], "R3 second byte", got[base + i][7:0], e_lo[i]);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog expired actual hung expected done");
    summary();
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(dac_cs_n == 1'b1 && dac_sclk == 1'b0 && dac_sdo == 1'b0 && busy == 1'b0,
        "R1 state in reset", {busy, dac_cs_n, dac_sclk, dac_sdo}, 4'b0100);
    rst = 1'b0;
    @(negedge clk);
    chk(dac_cs_n == 1'b1 && dac_sclk == 1'b0 && dac_sdo == 1'b0 && busy == 1'b0,
        "R1 state after reset", {busy, dac_cs_n, dac_sclk, dac_sdo}, 4'b0100);

    // R2 R3: single record with junk in discarded bits
    e_lo[0] = 8'h3C; e_hi[0] = 8'hFA; e_ch[0] = 8'hC5;
    load_pkt(1);
    go_wait(base);
    compare(base, 1);

    // R6 sweep: channel bits, every high nibble, junk upper bits; last packet full
    for (int p = 0; p < 4; p++) begin
      int n;
      n = (p == 3) ? 21 : 16;
      for (int i = 0; i < n; i++) begin
        e_lo[i] = 8'(i * 37 + p * 91);
        e_hi[i] = {4'(i * 3 + p), 4'(i)};
        e_ch[i] = {2'(i + p), 6'(i * 7 + 5)};
      end
      load_pkt(n);
      go_wait(base);
      compare(base, n);
    end

    // R7: empty packet
    put(0, 8'd0);
    go_wait(base);
    chk(got_n == base, "R7 no frame for zero count", got_n - base, 0);
    chk(busy == 1'b0, "R7 busy cleared", busy, 0);

    // R9 R10: restart and buffer writes during a packet are refused
    for (int i = 0; i < 3; i++) begin
      e_lo[i] = 8'(8'h11 * (i + 1)); e_hi[i] = 8'(8'h05 + i); e_ch[i] = 8'(8'h40 * i);
    end
    load_pkt(3);
    base = got_n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    put(1, 8'hEE);
    put(3, 8'hFF);
    put(0, 8'd9);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    compare(base, 3);
    go_wait(base);
    compare(base, 3);  // R10: buffer kept original packet

    summary();
    $finish;
  end
endmodule